// File: doc/BRIEF.md
# Parallel Matrix Multiply Cell Array

This block forms the signed fixed-point product C = A x B. A has N_ROWS x K_INNER elements, B has K_INNER x M_COLS elements and C has N_ROWS x M_COLS elements. A start pulse opens a load window. The operands then arrive one element per cycle on a single input port: all of A first, then all of B, each in row-major order. Once the last element is in, the block computes on its own and raises a completion strobe. After that it streams C out, also one element per cycle and row-major, with a valid flag.

The array holds N_ROWS identical cells. Each cell has one multiplier and one accumulator, and cell r builds the entries of row r of C. The block makes one pass for each column of B. In that pass the column elements enter a register chain, one new element per cycle, and each stage of the chain hands its value to the next stage. On a given cycle, cell r takes the chain value at stage r and multiplies it by the A element of row r whose inner index equals the pass cycle minus r. Because of this stagger, every cell finishes a full dot product in K_INNER+N_ROWS-1 cycles. One more cycle writes the column into the result store. The total run therefore grows with the square of the dimension, not with its cube.

Top module: `mm_array`

## Requirements
- R1: While reset is held and after it is released, done_o and out_valid_o are 0 and out_data_o is 0.
- R2: After start_i, the block accepts one operand on each cycle that in_valid_i is high. The first N_ROWS*K_INNER accepted values are A in row-major order (A[i][j] at position i*K_INNER+j). The next K_INNER*M_COLS values are B in row-major order (B[j][k] at position j*K_INNER... counted as j*M_COLS+k after the A block).
- R3: Every element of C equals the exact signed sum of the products of A and B. This holds for full-scale inputs such as all operands at -32768, whose entries need more than 32 bits. Results are 40-bit two's complement.
- R4: done_o is high for exactly one cycle. That cycle is the (M_COLS*(K_INNER+N_ROWS)+1)-th cycle after the clock edge that accepts the last B element. With the default dimensions this is cycle 33, fewer than the 64 cycles that one sequential multiply-accumulate unit would need.
- R5: out_valid_o is high for exactly N_ROWS*M_COLS consecutive cycles, starting in the cycle after done_o. Over those cycles out_data_o carries C[i][k] in row-major order. out_valid_o never rises unless done_o was high in the cycle before.
- R6: in_valid_i and in_data_i have no effect while the block is not loading, that is during computation, the completion cycle and readout.
- R7: start_i at any time discards a partial load, clears the accumulators and the operand chain, ends any readout in the following cycle and restarts loading at position 0. A later run shows no residue from an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that opens a new load |
| in_valid_i | input | 1 | Operand strobe during loading |
| in_data_i | input | DATA_W | Signed operand, A elements then B elements |
| done_o | output | 1 | One-cycle pulse when every element of C is ready |
| out_valid_o | output | 1 | Readout strobe |
| out_data_o | output | ACC_W | Signed C element, row-major |

## Verification
Cycle counting starts at the clock edge that takes in the last B element. done_o is due in cycle M_COLS*(K_INNER+N_ROWS)+1 after that edge, and the N_ROWS*M_COLS readout cycles follow it directly. The bench drives and samples on the falling clock edge. It counts falling edges from that same edge until done_o appears, compares the count with the formula, and then reads exactly one element on each following falling edge before it checks that the strobe has dropped. Noise on the input port during computation, and a restart in the middle of a load, must leave these due cycles and the values from the bench's own triple-loop reference unchanged.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COMP,
    ST_STORE,
    ST_DONE,
    ST_OUT
  } mm_state_e;

  // index width, at least one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mm_cell.sv
module mm_cell #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 40
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [ACC_W-1:0]  acc_o
);

  logic signed [2*DATA_W-1:0] prod;
  assign prod = a_i * b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (en_i)  acc_o <= acc_o + ACC_W'(prod);
  end

endmodule

// File: rtl/mm_chain.sv
module mm_chain #(
  parameter int unsigned NUM = 4,
  parameter int unsigned W   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  en_i,
  input  logic [W-1:0]          feed_i,
  output logic [NUM-1:0][W-1:0] tap_o
);

  assign tap_o[0] = feed_i;

  for (genvar r = 1; r < NUM; r++) begin : g_stg
    logic [W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_q <= '0;
      else if (clr_i) q_q <= '0;
      else if (en_i)  q_q <= tap_o[r-1];
    end
    assign tap_o[r] = q_q;
  end

endmodule

// File: rtl/mm_array.sv
module mm_array
  import mm_pkg::*;
#(
  parameter int unsigned N_ROWS  = 4,
  parameter int unsigned K_INNER = 4,
  parameter int unsigned M_COLS  = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ACC_W   = 40
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  output logic                     done_o,
  output logic                     out_valid_o,
  output logic signed [ACC_W-1:0]  out_data_o
);

  localparam int unsigned A_SZ  = N_ROWS * K_INNER;
  localparam int unsigned B_SZ  = K_INNER * M_COLS;
  localparam int unsigned C_SZ  = N_ROWS * M_COLS;
  localparam int unsigned LD_SZ = A_SZ + B_SZ;
  localparam int unsigned PASS  = K_INNER + N_ROWS - 1;
  localparam int unsigned LD_W  = idx_w(LD_SZ);
  localparam int unsigned A_IW  = idx_w(A_SZ);
  localparam int unsigned B_IW  = idx_w(B_SZ);
  localparam int unsigned C_IW  = idx_w(C_SZ);
  localparam int unsigned T_W   = idx_w(PASS);
  localparam int unsigned COL_W = idx_w(M_COLS);

  mm_state_e         st_q;
  logic [LD_W-1:0]   ld_q;
  logic [T_W-1:0]    t_q;
  logic [COL_W-1:0]  col_q;
  logic [C_IW-1:0]   oc_q;

  logic signed [DATA_W-1:0] a_q [A_SZ];
  logic signed [DATA_W-1:0] b_q [B_SZ];
  logic signed [ACC_W-1:0]  c_q [C_SZ];
  logic signed [ACC_W-1:0]  acc_w [N_ROWS];

  logic                           clr, en;
  logic signed [DATA_W-1:0]       feed;
  logic [N_ROWS-1:0][DATA_W-1:0]  tap;

  assign clr = start_i || (st_q == ST_STORE);
  assign en  = !start_i && (st_q == ST_COMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ld_q  <= '0;
      t_q   <= '0;
      col_q <= '0;
      oc_q  <= '0;
    end else if (start_i) begin
      st_q <= ST_LOAD;
      ld_q <= '0;
    end else begin
      unique case (st_q)
        ST_LOAD: if (in_valid_i) begin
          ld_q <= ld_q + 1'b1;
          if (ld_q == LD_W'(LD_SZ - 1)) begin
            st_q  <= ST_COMP;
            t_q   <= '0;
            col_q <= '0;
          end
        end
        ST_COMP: begin
          t_q <= t_q + 1'b1;
          if (t_q == T_W'(PASS - 1)) st_q <= ST_STORE;
        end
        ST_STORE: begin
          t_q <= '0;
          if (col_q == COL_W'(M_COLS - 1)) st_q <= ST_DONE;
          else begin
            col_q <= col_q + 1'b1;
            st_q  <= ST_COMP;
          end
        end
        ST_DONE: begin
          st_q <= ST_OUT;
          oc_q <= '0;
        end
        ST_OUT: begin
          oc_q <= oc_q + 1'b1;
          if (oc_q == C_IW'(C_SZ - 1)) st_q <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  // operand store, A block first then B block
  always_ff @(posedge clk_i) begin
    if (st_q == ST_LOAD && in_valid_i && !start_i) begin
      if (int'(ld_q) < int'(A_SZ)) a_q[A_IW'(ld_q)] <= in_data_i;
      else b_q[B_IW'(int'(ld_q) - int'(A_SZ))] <= in_data_i;
    end
  end

  // column element entering the chain; zero once the column is exhausted
  always_comb begin
    feed = '0;
    if (int'(t_q) < int'(K_INNER))
      feed = b_q[B_IW'(int'(t_q) * int'(M_COLS) + int'(col_q))];
  end

  mm_chain #(
    .NUM (N_ROWS),
    .W   (DATA_W)
  ) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (en),
    .feed_i (feed),
    .tap_o  (tap)
  );

  for (genvar r = 0; r < N_ROWS; r++) begin : g_cell
    logic signed [DATA_W-1:0] a_sel;
    // cell r pairs chain stage r with A[r][t-r]
    always_comb begin
      a_sel = '0;
      if (int'(t_q) >= r && int'(t_q) - r < int'(K_INNER))
        a_sel = a_q[A_IW'(r * int'(K_INNER) + int'(t_q) - r)];
    end
    mm_cell #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W)
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (en),
      .a_i    (a_sel),
      .b_i    (tap[r]),
      .acc_o  (acc_w[r])
    );
  end

  always_ff @(posedge clk_i) begin
    if (st_q == ST_STORE && !start_i) begin
      for (int r = 0; r < int'(N_ROWS); r++)
        c_q[C_IW'(r * int'(M_COLS) + int'(col_q))] <= acc_w[r];
    end
  end

  assign done_o      = (st_q == ST_DONE);
  assign out_valid_o = (st_q == ST_OUT);
  assign out_data_o  = out_valid_o ? c_q[oc_q] : '0;

endmodule

// File: rtl/mm_array_chk.sv
module mm_array_chk #(
  parameter int unsigned N_ROWS = 4,
  parameter int unsigned M_COLS = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic done_o,
  input logic out_valid_o
);

  localparam int C_SZ = int'(N_ROWS * M_COLS);

  int run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= 0;
    else if (out_valid_o) run_q <= run_q + 1;
    else                  run_q <= 0;
  end

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_then_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> out_valid_o);

  p_out_after_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(done_o));

  p_out_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (run_q < C_SZ));

  p_done_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && out_valid_o));

  p_start_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!out_valid_o && !done_o));

endmodule

bind mm_array mm_array_chk #(
  .N_ROWS (N_ROWS),
  .M_COLS (M_COLS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .done_o      (done_o),
  .out_valid_o (out_valid_o)
);

// File: tb/sim_mm_array.sv
module sim_mm_array;

  localparam int N = 4;
  localparam int K = 4;
  localparam int M = 4;
  localparam int DW = 16;
  localparam int AW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic done;
  logic out_valid;
  logic signed [AW-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  int seed = 7;

  logic signed [DW-1:0] ma [N*K];
  logic signed [DW-1:0] mb [K*M];
  logic signed [AW-1:0] ref_c [N*M];

  always #2 clk = ~clk;

  mm_array #(
    .N_ROWS (N), .K_INNER (K), .M_COLS (M), .DATA_W (DW), .ACC_W (AW)
  ) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .done_o      (done),
    .out_valid_o (out_valid),
    .out_data_o  (out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic signed [DW-1:0] rnd();
    seed = seed * 1103515245 + 12345;
    return seed[30:15];
  endfunction

  task automatic compute_ref();
    for (int i = 0; i < N; i++)
      for (int k = 0; k < M; k++) begin
        longint s = 0;
        for (int j = 0; j < K; j++)
          s += longint'(ma[i*K+j]) * longint'(mb[j*M+k]);
        ref_c[i*M+k] = s[AW-1:0];
      end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  // load A then B, wait for done, read out C; noise drives the input port while busy
  task automatic run_mult(input string tag, input bit noise);
    int k;
    compute_ref();
    pulse_start();
    for (int e = 0; e < N*K + K*M; e++) begin
      in_valid = 1'b1;
      in_data = (e < N*K) ? ma[e] : mb[e - N*K];
      @(negedge clk);
    end
    in_valid = noise;
    in_data = noise ? 16'sh7fff : '0;
    k = 1;
    while (!done && k < 1000) begin
      @(negedge clk);
      k++;
    end
    // R4: completion cycle after last accepted element
    check(k == M*(K+N)+1, {"R4 latency ", tag}, k, M*(K+N)+1);
    check(k < N*K*M, {"R4 faster than sequential ", tag}, k, N*K*M);
    for (int e = 0; e < N*M; e++) begin
      @(negedge clk);
      if (noise) in_data = -in_data;
      check(out_valid == 1'b1, {"R5 valid ", tag}, out_valid, 1);
      check(done == 1'b0, {"R4 single pulse ", tag}, done, 0);
      // R2 and R3 element value in row-major order
      check(out_data == ref_c[e], {"R3 R2 element ", tag}, out_data, ref_c[e]);
    end
    @(negedge clk);
    check(out_valid == 1'b0, {"R5 run end ", tag}, out_valid, 0);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R1 done", done, 0);
    check(out_valid == 1'b0, "R1 valid", out_valid, 0);
    check(out_data == '0, "R1 data", out_data, 0);
  endtask

  task automatic t_identity();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < K; j++) ma[i*K+j] = (i == j) ? 16'sd1 : 16'sd0;
    for (int e = 0; e < K*M; e++) mb[e] = 16'(e * 3 - 20);
    run_mult("identity", 1'b0);
  endtask

  task automatic t_random();
    for (int e = 0; e < N*K; e++) ma[e] = rnd();
    for (int e = 0; e < K*M; e++) mb[e] = rnd();
    run_mult("random", 1'b0);
  endtask

  task automatic t_extreme();
    for (int e = 0; e < N*K; e++) ma[e] = 16'sh8000;
    for (int e = 0; e < K*M; e++) mb[e] = (e % 2 == 0) ? 16'sh8000 : 16'sh7fff;
    run_mult("full scale", 1'b0);
  endtask

  // R6: input activity while busy must not disturb the result
  task automatic t_noise();
    for (int e = 0; e < N*K; e++) ma[e] = 16'(e - 7);
    for (int e = 0; e < K*M; e++) mb[e] = 16'(11 - 2*e);
    run_mult("R6 noise", 1'b1);
  endtask

  // R7: partial load then restart
  task automatic t_restart();
    pulse_start();
    for (int e = 0; e < 5; e++) begin
      in_valid = 1'b1;
      in_data = 16'sh1234;
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int e = 0; e < N*K; e++) ma[e] = rnd();
    for (int e = 0; e < K*M; e++) mb[e] = rnd();
    run_mult("R7 restart", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_random();
    t_extreme();
    t_noise();
    t_restart();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule